// File: doc/BRIEF.md
# SPI Register Access Command Decoder

This block is the serial front end of a bus controller's register file. A host talks to it over a four-wire SPI link in mode 0. The first byte of each chip-select frame is taken as a command. Depending on the command, the block then takes an address, data, a mask, or nothing at all. It owns a small register array. Two registers in that array have fixed roles. The control register holds a requested operating mode. The status register mirrors the operating mode currently in effect.

The protocol engine that sits behind the registers reaches the same array through a plain internal read/write port. It receives transmit requests as one-cycle pulses, one line per transmit buffer. The SPI pins are sampled by the system clock through a synchronizer, so SCK must be slow compared with that clock (at least about eight system clocks per SCK phase).

Top module: `can_spi_regif`

## Requirements
- R1: After `rst_n` low, and again after the command byte 0xC0, the control register (address 0x0F) and the status register (address 0x0E) both read 0x80, which is the configuration mode code 100 in bits 7:5. Every other register reads 0x00.
- R2: Command 0x03 followed by an address byte shifts register contents out on `spi_miso`, MSB first. Bits change after falling SCK edges and are valid at rising edges. The address advances by one after each byte until chip select rises.
- R3: Command 0x02 followed by an address byte writes each further complete byte to the current address and then advances the address by one.
- R4: Command 0x05 is followed by an address byte, a mask byte and a data byte. The register becomes (old & ~mask) | (data & mask).
- R5: Command 0xA0 shifts out the status register byte, repeated for every further byte clocked in the frame.
- R6: A command byte whose bits 7:3 are 10000 pulses `txreq[i]` for exactly one clock cycle for each bit i of bits 2:0 that is set. Any other command gives no pulse.
- R7: Status bits 7:5 take the value of control bits 7:5 one clock later. SPI writes to the status register have no effect. Status bits 4:0 can be written only through the internal port.
- R8: Chip select going high in the middle of a byte discards that partial byte. The next frame starts again with a command byte.
- R9: Addresses at or above NREG read as 0x00 and ignore writes. A command byte that matches no command makes the rest of the frame have no effect.
- R10: `int_rdata` shows the register at `int_addr` combinationally. `int_we` writes `int_wdata` at the next clock edge. If an SPI write and an internal write hit the same register in the same cycle, the SPI write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sck | input | 1 | SPI serial clock, idle low |
| spi_csn | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| int_we | input | 1 | Internal port write strobe |
| int_addr | input | 8 | Internal port address |
| int_wdata | input | 8 | Internal port write data |
| int_rdata | output | 8 | Internal port read data |
| txreq | output | 3 | Per-buffer transmit request pulses |

## Verification
Each pin passes through a SYNC-stage synchronizer and then one edge-detect register. A received byte's result is therefore registered a few clocks after its eighth rising SCK edge: register writes, soft reset and `txreq` land within SYNC+3 clocks. The MISO bits of a read byte are loaded at the falling edge that follows and settle within SYNC+2 clocks of that edge. The bench holds each SCK phase for eight clocks and samples MISO just before it raises SCK. It reads `int_rdata` only after the frame has closed and the pins have settled. It catches `txreq` with a per-clock monitor, so the pulse width is counted rather than timed.

// File: rtl/can_spi_pkg.sv
// Shared constants and types for the SPI register front end.
// Assumes byte-wide registers and a fixed command encoding.
package can_spi_pkg;
    localparam int          BYTE_W      = 8;
    localparam int          NUM_TXB     = 3;
    localparam logic [7:0]  OP_RESET    = 8'hC0;
    localparam logic [7:0]  OP_READ     = 8'h03;
    localparam logic [7:0]  OP_WRITE    = 8'h02;
    localparam logic [7:0]  OP_BITMOD   = 8'h05;
    localparam logic [7:0]  OP_STATUS   = 8'hA0;
    localparam logic [4:0]  OP_TXREQ_HI = 5'b10000;
    localparam logic [7:0]  ADDR_STAT   = 8'h0E;
    localparam logic [7:0]  ADDR_CTRL   = 8'h0F;
    localparam logic [7:0]  MODE_DFLT   = 8'h80;

    typedef enum logic [2:0] {
        ST_CMD, ST_ADDR, ST_RDATA, ST_WDATA, ST_MASK, ST_MDATA, ST_STAT, ST_IGNORE
    } dec_state_t;

    typedef enum logic [1:0] {ACC_READ, ACC_WRITE, ACC_BITMOD} acc_kind_t;
endpackage

// File: rtl/spi_pin_sync.sv
// Synchronizes the SPI pins into clk and produces single-cycle SCK edge
// strobes that are qualified by an active chip select.
// Assumes SCK phases last several clk periods; SYNC >= 2.
module spi_pin_sync #(
    parameter int SYNC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic csn,
    input  logic mosi,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_act,
    output logic mosi_s
);
    logic [SYNC-1:0] sck_q, csn_q, mosi_q;
    logic            sck_d;

    // Synchronizer chains and the SCK edge-detect register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q  <= '0;
            csn_q  <= '1;
            mosi_q <= '0;
            sck_d  <= 1'b0;
        end else begin
            sck_q  <= {sck_q[SYNC-2:0], sck};
            csn_q  <= {csn_q[SYNC-2:0], csn};
            mosi_q <= {mosi_q[SYNC-2:0], mosi};
            sck_d  <= sck_q[SYNC-1];
        end
    end

    // Edge strobes exist only inside a frame.
    always_comb begin
        cs_act   = ~csn_q[SYNC-1];
        mosi_s   = mosi_q[SYNC-1];
        sck_rise = cs_act &  sck_q[SYNC-1] & ~sck_d;
        sck_fall = cs_act & ~sck_q[SYNC-1] &  sck_d;
    end
endmodule

// File: rtl/spi_byte_shift.sv
// Mode-0 byte shifter. Captures MOSI on rising strobes and flags each
// complete byte. Loads tx_byte at the first falling strobe of a byte and
// shifts it out MSB first on the falling strobes after that.
// Assumes the strobes come from spi_pin_sync; an inactive select clears all state.
module spi_byte_shift
    import can_spi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              mosi_s,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              rx_valid,
    output logic              tx_load,
    output logic              miso
);
    localparam int CW = $clog2(BYTE_W);

    logic [CW-1:0]     bitcnt;
    logic [BYTE_W-1:0] sh_in, sh_out;

    // Receive shifting, byte framing and transmit shifting.
    always_ff @(posedge clk) begin
        if (!rst_n || !cs_act) begin
            bitcnt   <= '0;
            sh_in    <= '0;
            sh_out   <= '0;
            rx_byte  <= '0;
            rx_valid <= 1'b0;
            tx_load  <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            tx_load  <= 1'b0;
            if (sck_rise) begin
                sh_in  <= {sh_in[BYTE_W-2:0], mosi_s};
                bitcnt <= bitcnt + 1'b1;
                if (bitcnt == CW'(BYTE_W - 1)) begin
                    rx_byte  <= {sh_in[BYTE_W-2:0], mosi_s};
                    rx_valid <= 1'b1;
                end
            end
            if (sck_fall) begin
                if (bitcnt == '0) begin
                    sh_out  <= tx_byte;
                    tx_load <= 1'b1;
                end else begin
                    sh_out <= {sh_out[BYTE_W-2:0], 1'b0};
                end
            end
        end
    end

    assign miso = sh_out[BYTE_W-1];

    // R8: a deselected frame leaves no partial byte behind.
    a_r8_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> (bitcnt == '0) && !rx_valid);
endmodule

// File: rtl/spi_cmd_decode.sv
// Frame-level command decoder. The first byte of a frame selects the
// operation. Later bytes are taken as address, data or mask. Register
// writes, soft reset and transmit pulses are registered outputs.
// Assumes rx_valid/tx_load pulses from spi_byte_shift.
module spi_cmd_decode
    import can_spi_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_act,
    input  logic               rx_valid,
    input  logic [BYTE_W-1:0]  rx_byte,
    input  logic               tx_load,
    input  logic [BYTE_W-1:0]  rd_data,
    input  logic [BYTE_W-1:0]  stat_byte,
    output logic [BYTE_W-1:0]  rd_addr,
    output logic [BYTE_W-1:0]  tx_byte,
    output logic               spi_we,
    output logic [BYTE_W-1:0]  spi_addr,
    output logic [BYTE_W-1:0]  spi_wdata,
    output logic               soft_rst,
    output logic [NUM_TXB-1:0] txreq
);
    dec_state_t        state;
    acc_kind_t         kind;
    logic [BYTE_W-1:0] ptr, mask;

    // Frame state machine, pointer handling and registered side effects.
    always_ff @(posedge clk) begin
        if (!rst_n || !cs_act) begin
            state     <= ST_CMD;
            kind      <= ACC_READ;
            ptr       <= '0;
            mask      <= '0;
            spi_we    <= 1'b0;
            spi_addr  <= '0;
            spi_wdata <= '0;
            soft_rst  <= 1'b0;
            txreq     <= '0;
        end else begin
            spi_we   <= 1'b0;
            soft_rst <= 1'b0;
            txreq    <= '0;
            if (tx_load && state == ST_RDATA)
                ptr <= ptr + 1'b1;
            if (rx_valid) begin
                unique case (state)
                    ST_CMD: begin
                        state <= ST_IGNORE;
                        if (rx_byte == OP_RESET) begin
                            soft_rst <= 1'b1;
                        end else if (rx_byte == OP_READ) begin
                            kind <= ACC_READ;   state <= ST_ADDR;
                        end else if (rx_byte == OP_WRITE) begin
                            kind <= ACC_WRITE;  state <= ST_ADDR;
                        end else if (rx_byte == OP_BITMOD) begin
                            kind <= ACC_BITMOD; state <= ST_ADDR;
                        end else if (rx_byte == OP_STATUS) begin
                            state <= ST_STAT;
                        end else if (rx_byte[7:3] == OP_TXREQ_HI) begin
                            txreq <= rx_byte[NUM_TXB-1:0];
                        end
                    end
                    ST_ADDR: begin
                        ptr <= rx_byte;
                        unique case (kind)
                            ACC_READ:   state <= ST_RDATA;
                            ACC_WRITE:  state <= ST_WDATA;
                            default:    state <= ST_MASK;
                        endcase
                    end
                    ST_WDATA: begin
                        spi_we    <= 1'b1;
                        spi_addr  <= ptr;
                        spi_wdata <= rx_byte;
                        ptr       <= ptr + 1'b1;
                    end
                    ST_MASK: begin
                        mask  <= rx_byte;
                        state <= ST_MDATA;
                    end
                    ST_MDATA: begin
                        spi_we    <= 1'b1;
                        spi_addr  <= ptr;
                        spi_wdata <= (rd_data & ~mask) | (rx_byte & mask);
                        state     <= ST_IGNORE;
                    end
                    default: ;
                endcase
            end
        end
    end

    // Byte offered to the shifter at the start of each outgoing byte.
    always_comb begin
        rd_addr = ptr;
        unique case (state)
            ST_RDATA: tx_byte = rd_data;
            ST_STAT:  tx_byte = stat_byte;
            default:  tx_byte = '0;
        endcase
    end

    // R6: transmit requests last one clock.
    a_r6_txreq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (txreq != '0) |=> (txreq == '0));
    // R3: register writes come only from a byte received inside a frame.
    a_r3_write_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        spi_we |-> $past(cs_act) && $past(rx_valid));
endmodule

// File: rtl/can_spi_regs.sv
// Byte register array with an SPI write port, an internal read/write port
// and a pointer read port. The status register tracks the control register's
// mode field and cannot be written over SPI.
// Assumes NREG > ADDR_CTRL; addresses at or above NREG are not present.
module can_spi_regs
    import can_spi_pkg::*;
#(
    parameter int NREG = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              spi_we,
    input  logic [BYTE_W-1:0] spi_addr,
    input  logic [BYTE_W-1:0] spi_wdata,
    input  logic              int_we,
    input  logic [BYTE_W-1:0] int_addr,
    input  logic [BYTE_W-1:0] int_wdata,
    input  logic [BYTE_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    output logic [BYTE_W-1:0] int_rdata,
    output logic [BYTE_W-1:0] stat_byte
);
    localparam int AW = $clog2(NREG);

    logic [BYTE_W-1:0] regs [NREG];

    // Register updates: reset defaults, mode mirroring, SPI over internal writes.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NREG; i++) begin
            if (!rst_n || soft_rst) begin
                regs[i] <= (BYTE_W'(i) == ADDR_CTRL || BYTE_W'(i) == ADDR_STAT) ? MODE_DFLT : '0;
            end else if (BYTE_W'(i) == ADDR_STAT) begin
                regs[i][7:5] <= regs[ADDR_CTRL[AW-1:0]][7:5];
                if (int_we && int_addr == ADDR_STAT)
                    regs[i][4:0] <= int_wdata[4:0];
            end else if (spi_we && spi_addr == BYTE_W'(i)) begin
                regs[i] <= spi_wdata;
            end else if (int_we && int_addr == BYTE_W'(i)) begin
                regs[i] <= int_wdata;
            end
        end
    end

    // Read ports; absent addresses return zero.
    always_comb begin
        rd_data   = (rd_addr  < BYTE_W'(NREG)) ? regs[rd_addr[AW-1:0]]  : '0;
        int_rdata = (int_addr < BYTE_W'(NREG)) ? regs[int_addr[AW-1:0]] : '0;
        stat_byte = regs[ADDR_STAT[AW-1:0]];
    end

    // R7: the current mode follows the requested mode one clock later.
    a_r7_mode_follow: assert property (@(posedge clk) disable iff (!rst_n)
        !soft_rst |=> regs[ADDR_STAT[AW-1:0]][7:5] == $past(regs[ADDR_CTRL[AW-1:0]][7:5]));
    // R1: the reset command returns both mode fields to configuration.
    a_r1_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> regs[ADDR_CTRL[AW-1:0]] == MODE_DFLT && regs[ADDR_STAT[AW-1:0]] == MODE_DFLT);
endmodule

// File: rtl/can_spi_regif.sv
// Top level: SPI slave command front end for a controller register file.
// Chains pin synchronizer, byte shifter, command decoder and register array.
// Assumes SCK phases of at least SYNC+4 clk periods.
module can_spi_regif
    import can_spi_pkg::*;
#(
    parameter int NREG = 16,
    parameter int SYNC = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               spi_sck,
    input  logic               spi_csn,
    input  logic               spi_mosi,
    output logic               spi_miso,
    input  logic               int_we,
    input  logic [7:0]         int_addr,
    input  logic [7:0]         int_wdata,
    output logic [7:0]         int_rdata,
    output logic [NUM_TXB-1:0] txreq
);
    logic              sck_rise, sck_fall, cs_act, mosi_s;
    logic              rx_valid, tx_load, spi_we, soft_rst;
    logic [BYTE_W-1:0] rx_byte, tx_byte, rd_addr, rd_data, stat_byte;
    logic [BYTE_W-1:0] spi_addr, spi_wdata;

    spi_pin_sync #(.SYNC(SYNC)) u_sync (
        .clk(clk), .rst_n(rst_n), .sck(spi_sck), .csn(spi_csn), .mosi(spi_mosi),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_act(cs_act), .mosi_s(mosi_s)
    );

    spi_byte_shift u_shift (
        .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .sck_rise(sck_rise),
        .sck_fall(sck_fall), .mosi_s(mosi_s), .tx_byte(tx_byte),
        .rx_byte(rx_byte), .rx_valid(rx_valid), .tx_load(tx_load), .miso(spi_miso)
    );

    spi_cmd_decode u_dec (
        .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .tx_load(tx_load), .rd_data(rd_data),
        .stat_byte(stat_byte), .rd_addr(rd_addr), .tx_byte(tx_byte),
        .spi_we(spi_we), .spi_addr(spi_addr), .spi_wdata(spi_wdata),
        .soft_rst(soft_rst), .txreq(txreq)
    );

    can_spi_regs #(.NREG(NREG)) u_regs (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .spi_we(spi_we),
        .spi_addr(spi_addr), .spi_wdata(spi_wdata), .int_we(int_we),
        .int_addr(int_addr), .int_wdata(int_wdata), .rd_addr(rd_addr),
        .rd_data(rd_data), .int_rdata(int_rdata), .stat_byte(stat_byte)
    );
endmodule

// File: tb/tb_can_spi_regif.sv
// Self-checking bench: a vector table of write / bit-modify / read-back,
// then directed tests for reset, status, modes, transmit pulses and corners.
module tb_can_spi_regif;
    localparam int HP = 8;    // clk cycles per SCK phase

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spi_sck = 1'b0, spi_csn = 1'b1, spi_mosi = 1'b0;
    logic       spi_miso;
    logic       int_we = 1'b0;
    logic [7:0] int_addr = '0, int_wdata = '0, int_rdata;
    logic [2:0] txreq;

    int n_chk = 0, n_fail = 0;
    logic [2:0] tx_seen = '0;
    int         tx_cycles = 0;
    logic [7:0] tx [8];
    logic [7:0] rx [8];

    can_spi_regif dut (
        .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_csn(spi_csn),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .int_we(int_we),
        .int_addr(int_addr), .int_wdata(int_wdata), .int_rdata(int_rdata),
        .txreq(txreq)
    );

    always #2 clk = ~clk;   // 250 MHz

    // Transmit-request monitor: which bits pulsed and for how many cycles.
    always @(posedge clk) begin
        tx_seen <= tx_seen | txreq;
        if (txreq != '0) tx_cycles <= tx_cycles + 1;
    end

    // {addr, first value, mask, data, expected}
    localparam logic [39:0] VEC [6] = '{
        {8'h00, 8'hA5, 8'h0F, 8'h3C, 8'hAC},
        {8'h03, 8'hFF, 8'h81, 8'h00, 8'h7E},
        {8'h07, 8'h00, 8'hF0, 8'h5A, 8'h50},
        {8'h0D, 8'h12, 8'h00, 8'hFF, 8'h12},
        {8'h09, 8'h3C, 8'hFF, 8'hC3, 8'hC3},
        {8'h05, 8'h55, 8'hAA, 8'hFF, 8'hFF}
    };

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One frame of nbytes; stop_bits > 0 aborts after that many bits of the last byte.
    task automatic frame(input int nbytes, input int stop_bits);
        spi_csn = 1'b0;
        wait_clk(HP);
        for (int b = 0; b < nbytes; b++) begin
            for (int k = 7; k >= 0; k--) begin
                if (stop_bits > 0 && b == nbytes - 1 && (7 - k) == stop_bits) break;
                spi_mosi = tx[b][k];
                wait_clk(HP);
                rx[b][k] = spi_miso;
                spi_sck = 1'b1;
                wait_clk(HP);
                spi_sck = 1'b0;
            end
        end
        wait_clk(HP);
        spi_csn = 1'b1;
        wait_clk(4 * HP);
    endtask

    task automatic spi_wr(input logic [7:0] a, input logic [7:0] d);
        tx[0] = 8'h02; tx[1] = a; tx[2] = d; frame(3, 0);
    endtask

    task automatic spi_rd(input logic [7:0] a, input int n);
        tx[0] = 8'h03; tx[1] = a;
        for (int i = 2; i < 8; i++) tx[i] = 8'h00;
        frame(2 + n, 0);
    endtask

    task automatic int_read(input logic [7:0] a, output logic [7:0] d);
        int_addr = a;
        wait_clk(1);
        d = int_rdata;
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        logic [7:0] v;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(2);

        // R1: reset state
        int_read(8'h0F, v); check("R1 ctrl after reset", v, 8'h80);
        int_read(8'h0E, v); check("R1 status after reset", v, 8'h80);
        int_read(8'h03, v); check("R1 plain reg after reset", v, 8'h00);

        // R3 / R4 / R2: vector table
        foreach (VEC[i]) begin
            spi_wr(VEC[i][39:32], VEC[i][31:24]);
            tx[0] = 8'h05; tx[1] = VEC[i][39:32]; tx[2] = VEC[i][23:16]; tx[3] = VEC[i][15:8];
            frame(4, 0);
            spi_rd(VEC[i][39:32], 1);
            check("R4 bit modify SPI readback", rx[2], VEC[i][7:0]);
            int_read(VEC[i][39:32], v);
            check("R3 write/modify internal view", v, VEC[i][7:0]);
        end

        // R3 and R2: sequential write and read with auto-increment
        tx[0] = 8'h02; tx[1] = 8'h01; tx[2] = 8'h11; tx[3] = 8'h22; tx[4] = 8'h33;
        frame(5, 0);
        int_read(8'h03, v); check("R3 auto-increment third byte", v, 8'h33);
        spi_rd(8'h01, 3);
        check("R2 seq read byte0", rx[2], 8'h11);
        check("R2 seq read byte1", rx[3], 8'h22);
        check("R2 seq read byte2", rx[4], 8'h33);

        // R5 / R7: quick status read follows mode request
        tx[0] = 8'hA0; tx[1] = 8'h00; tx[2] = 8'h00; frame(3, 0);
        check("R5 status read config", rx[1], 8'h80);
        check("R5 status repeats", rx[2], 8'h80);
        spi_wr(8'h0F, 8'h40);
        tx[0] = 8'hA0; tx[1] = 8'h00; frame(2, 0);
        check("R7 status mode loopback", rx[1], 8'h40);
        spi_wr(8'h0E, 8'hFF);
        int_read(8'h0E, v); check("R7 status ignores SPI write", v, 8'h40);
        int_addr = 8'h0E; int_wdata = 8'hFF; int_we = 1'b1; wait_clk(1); int_we = 1'b0;
        int_read(8'h0E, v); check("R7 status low bits via internal port", v, 8'h5F);

        // R10: internal write seen over SPI
        int_addr = 8'h02; int_wdata = 8'h6E; int_we = 1'b1; wait_clk(1); int_we = 1'b0;
        spi_rd(8'h02, 1); check("R10 internal write SPI readback", rx[2], 8'h6E);

        // R9: absent address and unknown command
        spi_wr(8'h20, 8'h99);
        spi_rd(8'h20, 1); check("R9 absent address reads zero", rx[2], 8'h00);
        tx[0] = 8'h11; tx[1] = 8'h02; tx[2] = 8'hEE; frame(3, 0);
        int_read(8'h02, v); check("R9 unknown command no effect", v, 8'h6E);

        // R8: aborted data byte is dropped, next frame decodes fresh
        tx[0] = 8'h02; tx[1] = 8'h02; tx[2] = 8'hFF; frame(3, 4);
        int_read(8'h02, v); check("R8 abort leaves register", v, 8'h6E);
        spi_rd(8'h02, 1); check("R8 next frame decodes", rx[2], 8'h6E);

        // R6: transmit request pulses
        tx_seen = '0; tx_cycles = 0;
        tx[0] = 8'h85; frame(1, 0);
        check("R6 txreq bits for 0x85", {5'b0, tx_seen}, 8'h05);
        check("R6 txreq single cycle", 8'(tx_cycles), 8'h01);
        tx_seen = '0; tx_cycles = 0;
        tx[0] = 8'h8F; frame(1, 0);
        check("R6 no txreq for 0x8F", {5'b0, tx_seen}, 8'h00);
        tx_seen = '0;
        tx[0] = 8'h87; frame(1, 0);
        check("R6 all buffers for 0x87", {5'b0, tx_seen}, 8'h07);

        // R1: reset command restores defaults
        tx[0] = 8'hC0; frame(1, 0);
        int_read(8'h0F, v); check("R1 ctrl after reset command", v, 8'h80);
        int_read(8'h0E, v); check("R1 status after reset command", v, 8'h80);
        int_read(8'h02, v); check("R1 reg cleared by reset command", v, 8'h00);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule